// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

A 16-bit general-purpose timer driven from a selectable count source through an 8-bit prescaler. Software sets it up through a small register bus: a mode word, a reference value, a capture value, the live counter and an event word. Each time the counter is due to advance while it holds the reference value, the block records a reference event. Depending on the mode, it then restarts the count from zero, flips or pulses an output pin, and raises an interrupt request.

A typical use is a periodic tick. The reference is loaded with N, restart-on-match and the interrupt are enabled, and the handler writes a one to the reference event bit. The interrupt then repeats every (N+1) counter steps. A capture input records the counter value on a chosen edge of an external signal.

Register addresses: 0 mode, 1 reference, 2 capture (read-only), 3 counter, 4 event. Unused addresses read as zero.

Top module: `ptmr_top`

## Requirements
- R1: After synchronous reset the mode reads 0x0000, the reference reads 0xFFFF, the capture, counter and event words read 0, and `tmr_out` and `tmr_irq` are low.
- R2: The mode word holds the following fields:
  - bit 0: run enable.
  - bits 2:1: count source. 00 is off, 01 is every clock, 10 is every 16th clock, 11 is each rising edge of `ext_clk_in`.
  - bit 3: restart on match.
  - bit 4: reference interrupt enable.
  - bit 5: output mode, 1 for toggle and 0 for pulse.
  - bits 7:6: capture edge, 00 none, 01 rising, 10 falling, 11 both.
  - bits 15:8: prescale, equal to the divide ratio minus one.
  
  The mode word reads back exactly as written.
- R3: With run clear, or source 00, the counter holds its value and no counter step occurs. Clearing run also resets the prescaler and the divide-by-16 stage.
- R4: The counter steps once for every (prescale+1) source ticks.
- R5: A counter step taken while the counter equals the reference is a match. A match sets event bit 1.
- R6: On a match with restart set, the counter becomes 0. Without restart it keeps counting and wraps at 0xFFFF.
- R7: In toggle mode each match inverts `tmr_out`. In pulse mode `tmr_out` is high for exactly the cycle after a match.
- R8: `tmr_irq` is high exactly when event bit 1 is set and mode bit 4 is set.
- R9: Writing the event word clears each event bit written as one and leaves bits written as zero unchanged. A set in the same cycle wins over a clear.
- R10: Any write to the counter address clears the counter to 0, whatever the data.
- R11: On the selected edge of `cap_in`, the capture word loads the counter value and event bit 0 sets. This happens whether or not the timer runs.
- R12: The reference word reads back as written, and reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| ext_clk_in | input | 1 | External count source, rising edges counted |
| cap_in | input | 1 | Capture trigger input |
| tmr_out | output | 1 | Toggle or pulse output |
| tmr_irq | output | 1 | Reference interrupt request |

## Verification
The assertions take for granted that `ext_clk_in` and `cap_in` are already synchronous to `clk` and carry no unknown values. They also assume that a write is one single-cycle `bus_sel`/`bus_wr` pulse with defined data. The bench meets this by driving every input at the falling edge from known random values. Its addresses never point outside 0 to 7.

Random mode words mostly carry small prescale and reference values, so that matches, restarts, toggles and clear-versus-set collisions happen often. Directed runs add the 0x00FF periodic case, the divide-by-16 source and the largest prescale.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int DATA_W   = 16;
    localparam int PS_W     = 8;
    localparam int SLOW_DIV = 16;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_REF  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CAP  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_EVT  = 3'd4;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_FAST = 2'b01,
        SRC_SLOW = 2'b10,
        SRC_EXT  = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        CAP_NONE = 2'b00,
        CAP_RISE = 2'b01,
        CAP_FALL = 2'b10,
        CAP_BOTH = 2'b11
    } cap_e;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        cap_e            cap;
        logic            toggle;
        logic            ref_ie;
        logic            restart;
        src_e            src;
        logic            run;
    } mode_t;

    function automatic logic cap_fire(cap_e sel, logic now, logic prev);
        logic rise;
        logic fall;
        rise = now & ~prev;
        fall = ~now & prev;
        case (sel)
            CAP_RISE: return rise;
            CAP_FALL: return fall;
            CAP_BOTH: return rise | fall;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ptmr_tick_gen.sv
module ptmr_tick_gen
    import ptmr_pkg::*;
#(
    parameter int PW   = PS_W,
    parameter int SDIV = SLOW_DIV
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  src_e          src,
    input  logic [PW-1:0] ps,
    input  logic          ext_in,
    output logic          cnt_tick
);
    localparam int DIV_W = (SDIV > 1) ? $clog2(SDIV) : 1;

    logic [DIV_W-1:0] div_q;
    logic [PW-1:0]    pre_q;
    logic             ext_prev_q;
    logic             slow_tick;
    logic             src_tick;

    assign slow_tick = (div_q == DIV_W'(SDIV - 1));

    always_comb begin
        src_tick = 1'b0;
        if (run) begin
            case (src)
                SRC_FAST: src_tick = 1'b1;
                SRC_SLOW: src_tick = slow_tick;
                SRC_EXT:  src_tick = ext_in & ~ext_prev_q;
                default:  src_tick = 1'b0;
            endcase
        end
    end

    assign cnt_tick = src_tick && (pre_q == ps);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q      <= '0;
            pre_q      <= '0;
            ext_prev_q <= 1'b0;
        end else begin
            ext_prev_q <= ext_in;
            if (!run || src != SRC_SLOW)
                div_q <= '0;
            else if (slow_tick)
                div_q <= '0;
            else
                div_q <= div_q + 1'b1;
            if (!run)
                pre_q <= '0;
            else if (src_tick)
                pre_q <= (pre_q == ps) ? '0 : pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/ptmr_count_cmp.sv
module ptmr_count_cmp
    import ptmr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_tick,
    input  logic         cnt_clr,
    input  logic [W-1:0] ref_val,
    input  logic         restart,
    input  logic         toggle,
    output logic [W-1:0] cnt,
    output logic         match,
    output logic         pin_out
);
    logic [W-1:0] cnt_q;
    logic         out_q;

    assign match   = cnt_tick && (cnt_q == ref_val);
    assign cnt     = cnt_q;
    assign pin_out = out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else begin
            if (cnt_clr)
                cnt_q <= '0;
            else if (cnt_tick)
                cnt_q <= (match && restart) ? '0 : cnt_q + 1'b1;
            if (toggle)
                out_q <= match ? ~out_q : out_q;
            else
                out_q <= match;
        end
    end

endmodule

// File: rtl/ptmr_capture.sv
module ptmr_capture
    import ptmr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_in,
    input  cap_e         sel,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cap_val,
    output logic         cap_hit
);
    logic         prev_q;
    logic [W-1:0] val_q;

    assign cap_hit = cap_fire(sel, cap_in, prev_q);
    assign cap_val = val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            val_q  <= '0;
        end else begin
            prev_q <= cap_in;
            if (cap_hit)
                val_q <= cnt;
        end
    end

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_clk_in,
    input  logic              cap_in,
    output logic              tmr_out,
    output logic              tmr_irq
);
    mode_t             mode_q;
    logic [DATA_W-1:0] ref_q;
    logic              ref_evt;
    logic              cap_evt;
    logic              wr;
    logic              cnt_clr;
    logic              evt_clr_ref;
    logic              evt_clr_cap;
    logic              cnt_tick;
    logic              match;
    logic              run;
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] cap_val;
    logic              cap_hit;

    assign wr          = bus_sel && bus_wr;
    assign cnt_clr     = wr && (bus_addr == A_CNT);
    assign evt_clr_ref = wr && (bus_addr == A_EVT) && bus_wdata[1];
    assign evt_clr_cap = wr && (bus_addr == A_EVT) && bus_wdata[0];
    assign run         = mode_q.run;

    ptmr_tick_gen #(.PW(PS_W), .SDIV(SLOW_DIV)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .run      (mode_q.run),
        .src      (mode_q.src),
        .ps       (mode_q.ps),
        .ext_in   (ext_clk_in),
        .cnt_tick (cnt_tick)
    );

    ptmr_count_cmp #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cnt_tick (cnt_tick),
        .cnt_clr  (cnt_clr),
        .ref_val  (ref_q),
        .restart  (mode_q.restart),
        .toggle   (mode_q.toggle),
        .cnt      (cnt),
        .match    (match),
        .pin_out  (tmr_out)
    );

    ptmr_capture #(.W(DATA_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .cap_in  (cap_in),
        .sel     (mode_q.cap),
        .cnt     (cnt),
        .cap_val (cap_val),
        .cap_hit (cap_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            ref_q   <= '1;
            ref_evt <= 1'b0;
            cap_evt <= 1'b0;
        end else begin
            if (wr && bus_addr == A_MODE)
                mode_q <= mode_t'(bus_wdata);
            if (wr && bus_addr == A_REF)
                ref_q <= bus_wdata;
            if (match)
                ref_evt <= 1'b1;
            else if (evt_clr_ref)
                ref_evt <= 1'b0;
            if (cap_hit)
                cap_evt <= 1'b1;
            else if (evt_clr_cap)
                cap_evt <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            A_MODE:  bus_rdata = DATA_W'(mode_q);
            A_REF:   bus_rdata = ref_q;
            A_CAP:   bus_rdata = cap_val;
            A_CNT:   bus_rdata = cnt;
            A_EVT:   bus_rdata = {{(DATA_W-2){1'b0}}, ref_evt, cap_evt};
            default: bus_rdata = '0;
        endcase
    end

    assign tmr_irq = ref_evt && mode_q.ref_ie;

endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
    import ptmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic              cnt_tick,
    input logic              cnt_clr,
    input logic              match,
    input logic              restart,
    input logic              toggle,
    input logic              pin_out,
    input logic              ref_evt,
    input logic              evt_clr_ref,
    input logic [DATA_W-1:0] cnt
);
    AST_STOPPED_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !run |-> !cnt_tick); // R3
    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!cnt_tick && !cnt_clr) |=> $stable(cnt)); // R4
    AST_EVT_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        match |=> ref_evt); // R5
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        (match && restart && !cnt_clr) |=> (cnt == '0)); // R6
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (match && toggle) |=> (pin_out != $past(pin_out))); // R7
    AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (evt_clr_ref && !match) |=> !ref_evt); // R9
    AST_CNT_WRITE_ZERO: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (cnt == '0)); // R10
endmodule

bind ptmr_top ptmr_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .cnt_tick    (cnt_tick),
    .cnt_clr     (cnt_clr),
    .match       (match),
    .restart     (mode_q.restart),
    .toggle      (mode_q.toggle),
    .pin_out     (tmr_out),
    .ref_evt     (ref_evt),
    .evt_clr_ref (evt_clr_ref),
    .cnt         (cnt)
);

// File: tb/ptmr_top_bench.sv
`timescale 1ns/1ps
module ptmr_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_clk_in = 1'b0, cap_in = 1'b0;
    logic        tmr_out, tmr_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench reference state
    logic [15:0] m_mode, m_ref, m_cap, m_cnt;
    logic        m_revt, m_cevt, m_out, m_extp, m_capp;
    logic [3:0]  m_div;
    logic [7:0]  m_pre;

    always #2.5 clk = ~clk;

    ptmr_top u_ptmr_top (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk_in(ext_clk_in), .cap_in(cap_in),
        .tmr_out(tmr_out), .tmr_irq(tmr_irq)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_mode;
            3'd1: return m_ref;
            3'd2: return m_cap;
            3'd3: return m_cnt;
            3'd4: return {14'd0, m_revt, m_cevt};
            default: return 16'd0;
        endcase
    endfunction

    function automatic string addr_req(logic [2:0] a);
        case (a)
            3'd0: return "R2 mode";
            3'd2: return "R11 capture";
            3'd3: return "R4 counter";
            3'd4: return "R5 event";
            default: return "R12 ref/unused";
        endcase
    endfunction

    task automatic m_reset();
        m_mode = 16'h0000; m_ref = 16'hFFFF; m_cap = '0; m_cnt = '0;
        m_revt = 0; m_cevt = 0; m_out = 0; m_extp = 0; m_capp = 0;
        m_div = '0; m_pre = '0;
    endtask

    // one clock: drive at falling edge, advance the bench state, compare after the edge
    task automatic step(logic s, logic w, logic [2:0] a, logic [15:0] d, logic e, logic c);
        logic run, stick, ctick, mt, hit, wrr;
        logic [1:0] src, cs;
        logic [7:0] ps;
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        ext_clk_in = e; cap_in = c;
        run = m_mode[0]; src = m_mode[2:1]; ps = m_mode[15:8]; cs = m_mode[7:6];
        stick = run && (src == 2'b01 || (src == 2'b10 && m_div == 4'hF) ||
                        (src == 2'b11 && e && !m_extp));
        ctick = stick && (m_pre == ps);
        mt    = ctick && (m_cnt == m_ref);
        hit   = (cs[0] && c && !m_capp) || (cs[1] && !c && m_capp);
        wrr   = s && w;
        if (hit) begin m_cap = m_cnt; m_cevt = 1; end
        else if (wrr && a == 3'd4 && d[0]) m_cevt = 0;
        if (mt) m_revt = 1;
        else if (wrr && a == 3'd4 && d[1]) m_revt = 0;
        m_out = m_mode[5] ? (m_out ^ mt) : mt;
        if (wrr && a == 3'd3) m_cnt = 0;
        else if (ctick) m_cnt = (mt && m_mode[3]) ? 16'd0 : m_cnt + 16'd1;
        m_div = (!run || src != 2'b10) ? 4'd0 : m_div + 4'd1;
        if (!run) m_pre = 0;
        else if (stick) m_pre = (m_pre == ps) ? 8'd0 : m_pre + 8'd1;
        m_extp = e; m_capp = c;
        if (wrr && a == 3'd0) m_mode = d;
        if (wrr && a == 3'd1) m_ref = d;
        @(negedge clk);
        chk("R8 irq", {15'd0, tmr_irq}, {15'd0, m_revt & m_mode[4]});
        chk("R7 out", {15'd0, tmr_out}, {15'd0, m_out});
        chk(addr_req(a), bus_rdata, m_read(a));
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        step(1, 1, a, d, ext_clk_in, cap_in);
    endtask

    task automatic idle(int n, logic [2:0] a);
        for (int i = 0; i < n; i++) step(1, 0, a, 16'd0, ext_clk_in, cap_in);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        for (int a = 0; a < 5; a++) begin
            bus_addr = 3'(a); #0.1;
            chk("R1 reset read", bus_rdata, (a == 1) ? 16'hFFFF : 16'h0000);
        end
        chk("R1 reset out", {14'd0, tmr_out, tmr_irq}, 16'd0);

        // stopped setup, then periodic tick with reference 0x00FF
        wr(3'd1, 16'h00FF);
        wr(3'd0, 16'h0038);
        idle(5, 3'd3);                 // R3 stopped: counter stays 0
        chk("R3 stopped count", bus_rdata, 16'd0);
        wr(3'd0, 16'h003B);
        idle(256, 3'd3);
        chk("R6 restart at 0x00FF", bus_rdata, 16'd0);
        chk("R8 irq after match", {15'd0, tmr_irq}, 16'd1);
        wr(3'd4, 16'h0002);            // R9 clear
        chk("R9 cleared", {15'd0, tmr_irq}, 16'd0);
        idle(600, 3'd4);

        // divide by 16 with prescale 2, pulse output, no restart
        wr(3'd1, 16'h0004);
        wr(3'd3, 16'h1234);            // R10
        wr(3'd0, 16'h0215);
        idle(900, 3'd3);
        // largest prescale, every clock
        wr(3'd0, 16'hFF3B);
        wr(3'd1, 16'h0001);
        idle(1100, 3'd3);
        // external source with capture on both edges
        wr(3'd0, 16'h00FF);
        wr(3'd1, 16'h0003);
        for (int i = 0; i < 600; i++)
            step(1, 0, 3'(i % 5), 16'd0, 1'($urandom), 1'($urandom % 7 == 0));

        // constrained random mix
        for (int i = 0; i < 20000; i++) begin
            logic [2:0]  a;
            logic [15:0] d;
            logic        w;
            a = 3'($urandom % 8);
            w = ($urandom % 10) == 0;
            d = 16'($urandom);
            if (a == 3'd0) d[15:8] = ($urandom % 8 == 0) ? d[15:8] : 8'($urandom % 4);
            if (a == 3'd1) d = ($urandom % 8 == 0) ? d : 16'($urandom % 12);
            if (a == 3'd3 && ($urandom % 4) != 0) w = 1'b0;
            step(1, w, a, d, 1'($urandom), 1'($urandom % 5 == 0));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule